// File: doc/BRIEF.md
# Ten-Channel DMA Single-Transfer Scheduler

This block collects transfer requests for ten DMA channels and moves one data word at a time on the internal bus. Each channel has an enable, a source code that picks which request line wakes it, and an edge mode for its own timer input. A request is held as pending until it is serviced or the channel is disabled. When the bus is idle, the lowest-numbered pending channel wins. The block then asks the CPU for the bus, does one read and one write, and hands the bus back.

The CPU side is a plain request/grant pair. The data side reads a word during the read cycle, keeps it in a register, and drives it out during the write cycle. The channel number is shown alongside so that surrounding logic can form the addresses. Address and count updates are not part of this block.

Top module: `dma_sched`

## Requirements
- R1: After reset, `bus_req`, `rd_en` and `wr_en` are low.
- R2: When several enabled channels are pending as the scheduler leaves idle, the lowest channel number is served first. Channel 0 has the highest priority and this order is fixed.
- R3: A request on a channel whose `chan_en` bit is 0 is ignored. Clearing `chan_en` drops a request that is already pending, so that channel is never served.
- R4: A channel's 3-bit source code (bits `3*ch+2:3*ch` of `src_sel`) works as follows:
  - Codes 0 to 6 select the strobe `periph_req[code]`.
  - Code 7 selects the channel's own timer input `tmr_in[ch]`.
  - A strobe on any other line has no effect on that channel.
- R5: A channel's 2-bit edge mode (bits `2*ch+1:2*ch` of `edge_sel`) sets which timer-input edges count as a request:
  - 01 means rising edges only.
  - 10 means falling edges only.
  - 11 means both edges.
  - 00 means no edge is detected.
- R6: Assume a timer edge is first sampled at clock edge E0, the bus is idle and `bus_gnt` follows `bus_req` at once. Then `bus_req` rises at E3 and `rd_en` at E4. This gives at least three cycles from the synchronized edge to the read.
- R7: `rd_en` is asserted only in the cycle after `bus_gnt` was seen high with `bus_req` high. While `bus_gnt` stays low, the scheduler keeps holding `bus_req` and does not read.
- R8: Each grant produces exactly one cycle of `rd_en`, followed in the next cycle by exactly one cycle of `wr_en`. `wr_data` equals the `rd_data` present during the read cycle, and `xfer_ch` names the served channel.
- R9: `bus_req` is low in the cycle after every write cycle, even when other requests are still pending.
- R10: A serviced channel's pending request is cleared when its write completes, so one request strobe or edge yields exactly one transfer.
- R11: `xfer_ch` does not change while `bus_req` is held. A higher-priority request that arrives during a transfer is served only after the bus has been released and requested again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | NCH | Per-channel transfer enable |
| src_sel | input | NCH*SELW | Per-channel request source code |
| edge_sel | input | NCH*2 | Per-channel timer edge mode |
| periph_req | input | NPER | Peripheral request strobes |
| tmr_in | input | NCH | Asynchronous timer inputs, one per channel |
| bus_gnt | input | 1 | Bus grant from the CPU |
| bus_req | output | 1 | Bus request to the CPU |
| rd_en | output | 1 | Read cycle strobe |
| wr_en | output | 1 | Write cycle strobe |
| xfer_ch | output | CHW | Channel being served |
| rd_data | input | DW | Data returned in the read cycle |
| wr_data | output | DW | Data driven in the write cycle |

## Verification
The hardest situation to reach is a change of pending state while a transfer is already committed. Examples are a higher-priority request that must wait its turn, and a lower one that is withdrawn before it is ever served. The bench creates this by holding `bus_gnt` low, which parks the scheduler in its request state with one channel chosen. While the bus is held back, it strobes a higher-priority channel and withdraws another channel's enable, then releases the grant. The order of the logged writes must then show the parked channel first, the higher-priority one next, and the withdrawn one never.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } xfer_state_t;

  localparam logic [1:0] EDGE_OFF  = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;
endpackage

// File: rtl/dma_trig_edge.sv
module dma_trig_edge #(
  parameter int NCH = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] tmr_in,
  input  logic [2*NCH-1:0] edge_sel,
  output logic [NCH-1:0] trig
);
  logic [NCH-1:0] sync1, sync2, sync3;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= tmr_in;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_edge
    logic rise, fall;
    assign rise = sync2[i] & ~sync3[i];
    assign fall = ~sync2[i] & sync3[i];
    assign trig[i] = (edge_sel[2*i] & rise) | (edge_sel[2*i+1] & fall);
  end
endmodule

// File: rtl/dma_chan_req.sv
module dma_chan_req #(
  parameter int NCH  = 10,
  parameter int NPER = 7,
  parameter int SELW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    chan_en,
  input  logic [NCH*SELW-1:0] src_sel,
  input  logic [NPER-1:0]   periph_req,
  input  logic [NCH-1:0]    trig,
  input  logic [NCH-1:0]    clr_vec,
  output logic [NCH-1:0]    pend
);
  localparam int NCODE = 2**SELW;
  localparam logic [SELW-1:0] TMR_CODE = SELW'(NCODE - 1);

  logic [NCODE-1:0] req_ext;
  assign req_ext = NCODE'(periph_req);

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic [SELW-1:0] code;
    logic            hit;
    assign code = src_sel[i*SELW +: SELW];
    assign hit  = (code == TMR_CODE) ? trig[i] : req_ext[code];

    always_ff @(posedge clk) begin
      if (rst)             pend[i] <= 1'b0;
      else if (!chan_en[i]) pend[i] <= 1'b0;
      else if (hit)        pend[i] <= 1'b1;
      else if (clr_vec[i]) pend[i] <= 1'b0;
    end

    assert_disabled_clear_R3: assert property (@(posedge clk) disable iff (rst)
      !chan_en[i] |=> !pend[i]);
    assert_hold_until_served_R10: assert property (@(posedge clk) disable iff (rst)
      (pend[i] && chan_en[i] && !clr_vec[i]) |=> pend[i]);
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 10,
  parameter int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [CHW-1:0] win_idx,
  output logic [NCH-1:0] win_vec
);
  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) begin
        any     = 1'b1;
        win_idx = CHW'(i);
      end
    end
    win_vec = any ? (NCH'(1) << win_idx) : '0;
  end
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_sched_pkg::*;
#(
  parameter int NCH = 10,
  parameter int CHW = $clog2(NCH),
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           any,
  input  logic [CHW-1:0] win_idx,
  input  logic           bus_gnt,
  input  logic [DW-1:0]  rd_data,
  output logic           bus_req,
  output logic           rd_en,
  output logic           wr_en,
  output logic [CHW-1:0] xfer_ch,
  output logic [DW-1:0]  wr_data,
  output logic [NCH-1:0] clr_vec
);
  xfer_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bus_req <= 1'b0;
      rd_en   <= 1'b0;
      wr_en   <= 1'b0;
      xfer_ch <= '0;
      wr_data <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (any) begin
          state   <= ST_REQ;
          bus_req <= 1'b1;
          xfer_ch <= win_idx;
        end
        ST_REQ: if (bus_gnt) begin
          state <= ST_RD;
          rd_en <= 1'b1;
        end
        ST_RD: begin
          state   <= ST_WR;
          rd_en   <= 1'b0;
          wr_en   <= 1'b1;
          wr_data <= rd_data;
        end
        ST_WR: begin
          state   <= ST_IDLE;
          wr_en   <= 1'b0;
          bus_req <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign clr_vec = wr_en ? (NCH'(1) << xfer_ch) : '0;

  assert_rd_after_gnt_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_en) |-> $past(bus_gnt && bus_req));
  assert_wr_follows_rd_R8: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (wr_en && !rd_en));
  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));
  assert_release_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !bus_req);
  assert_ch_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_req && $past(bus_req)) |-> $stable(xfer_ch));
endmodule

// File: rtl/dma_sched.sv
module dma_sched #(
  parameter int NCH  = 10,
  parameter int NPER = 7,
  parameter int SELW = 3,
  parameter int DW   = 32,
  parameter int CHW  = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NCH-1:0]      chan_en,
  input  logic [NCH*SELW-1:0] src_sel,
  input  logic [NCH*2-1:0]    edge_sel,
  input  logic [NPER-1:0]     periph_req,
  input  logic [NCH-1:0]      tmr_in,
  input  logic                bus_gnt,
  output logic                bus_req,
  output logic                rd_en,
  output logic                wr_en,
  output logic [CHW-1:0]      xfer_ch,
  input  logic [DW-1:0]       rd_data,
  output logic [DW-1:0]       wr_data
);
  logic [NCH-1:0] trig, pend, clr_vec, win_vec;
  logic [CHW-1:0] win_idx;
  logic           any;

  dma_trig_edge #(.NCH(NCH)) u_edge (
    .clk(clk), .rst(rst), .tmr_in(tmr_in), .edge_sel(edge_sel), .trig(trig)
  );

  dma_chan_req #(.NCH(NCH), .NPER(NPER), .SELW(SELW)) u_req (
    .clk(clk), .rst(rst), .chan_en(chan_en), .src_sel(src_sel),
    .periph_req(periph_req), .trig(trig), .clr_vec(clr_vec), .pend(pend)
  );

  dma_prio_arb #(.NCH(NCH), .CHW(CHW)) u_arb (
    .req(pend), .any(any), .win_idx(win_idx), .win_vec(win_vec)
  );

  dma_xfer_fsm #(.NCH(NCH), .CHW(CHW), .DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .any(any), .win_idx(win_idx), .bus_gnt(bus_gnt),
    .rd_data(rd_data), .bus_req(bus_req), .rd_en(rd_en), .wr_en(wr_en),
    .xfer_ch(xfer_ch), .wr_data(wr_data), .clr_vec(clr_vec)
  );

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win_vec) && ((win_vec & ~pend) == '0));
  assert_pick_lowest_R2: assert property (@(posedge clk) disable iff (rst)
    (any && !bus_req) |=> ((pend & ((NCH'(1) << xfer_ch) - NCH'(1))) == '0) || !bus_req);
endmodule

// File: tb/dma_sched_test.sv
module dma_sched_test;
  localparam int NCH = 10, NPER = 7, SELW = 3, DW = 32, CHW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [NCH-1:0] chan_en = '0;
  logic [NCH*SELW-1:0] src_sel = '0;
  logic [NCH*2-1:0] edge_sel = '0;
  logic [NPER-1:0] periph_req = '0;
  logic [NCH-1:0] tmr_in = '0;
  logic gnt_block = 1'b0;
  logic bus_gnt, bus_req, rd_en, wr_en;
  logic [CHW-1:0] xfer_ch;
  logic [DW-1:0] rd_data, wr_data;

  int total = 0, bad = 0;
  int log_ch [0:63];
  int log_n = 0, data_bad = 0, rel_bad = 0;
  logic prev_wr = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] word_for(input logic [CHW-1:0] ch);
    return 32'h5A3C_0100 ^ (DW'(ch) * 32'h0101_1011);
  endfunction

  assign bus_gnt = bus_req & ~gnt_block;
  assign rd_data = rd_en ? word_for(xfer_ch) : 32'hDEAD_0000;

  dma_sched uut (
    .clk(clk), .rst(rst), .chan_en(chan_en), .src_sel(src_sel),
    .edge_sel(edge_sel), .periph_req(periph_req), .tmr_in(tmr_in),
    .bus_gnt(bus_gnt), .bus_req(bus_req), .rd_en(rd_en), .wr_en(wr_en),
    .xfer_ch(xfer_ch), .rd_data(rd_data), .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (wr_en) begin
        if (log_n < 64) log_ch[log_n] = int'(xfer_ch);
        log_n++;
        if (wr_data !== word_for(xfer_ch)) data_bad++;
      end
      if (prev_wr && bus_req) rel_bad++;
      prev_wr = wr_en;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(input int ch, input bit en, input logic [2:0] code,
                     input logic [1:0] es);
    chan_en[ch] = en;
    src_sel[ch*SELW +: SELW] = code;
    edge_sel[ch*2 +: 2] = es;
  endtask

  task automatic strobe(input logic [NPER-1:0] lines);
    periph_req = lines;
    @(negedge clk);
    periph_req = '0;
  endtask

  task automatic clear_all();
    chan_en = '0;
    tick(12);
  endtask

  task automatic t_reset();
    check(bus_req === 1'b0 && rd_en === 1'b0 && wr_en === 1'b0, "R1 reset outputs",
          {29'd0, bus_req, rd_en, wr_en}, 0);
  endtask

  task automatic t_latency();
    int n0;
    cfg(3, 1'b1, 3'd7, 2'b01);
    n0 = log_n;
    tmr_in[3] = 1'b1;
    tick(3);
    check(bus_req === 1'b0, "R6 no request before E3", bus_req, 0);
    tick(1);
    check(bus_req === 1'b1 && rd_en === 1'b0, "R6 request at E3", {bus_req, rd_en}, 2'b10);
    tick(1);
    check(rd_en === 1'b1 && wr_en === 1'b0, "R6 read at E4", {rd_en, wr_en}, 2'b10);
    tick(1);
    check(wr_en === 1'b1 && rd_en === 1'b0 && xfer_ch === 4'd3, "R8 write follows read",
          {rd_en, wr_en, xfer_ch}, {2'b01, 4'd3});
    check(wr_data === word_for(4'd3), "R8 write data", wr_data, word_for(4'd3));
    tick(1);
    check(bus_req === 1'b0 && wr_en === 1'b0, "R9 release after write", bus_req, 0);
    tick(8);
    check(log_n - n0 == 1, "R10 one edge one transfer", log_n - n0, 1);
    tmr_in[3] = 1'b0;
    tick(12);
    check(log_n - n0 == 1, "R5 falling ignored in rise mode", log_n - n0, 1);
    clear_all();
  endtask

  task automatic t_edges();
    int n0;
    cfg(5, 1'b1, 3'd7, 2'b10);
    cfg(6, 1'b1, 3'd7, 2'b11);
    cfg(7, 1'b1, 3'd7, 2'b00);
    n0 = log_n;
    tmr_in[7:5] = 3'b111;
    tick(15);
    check(log_n - n0 == 1 && log_ch[n0] == 6, "R5 rise: only both-mode channel",
          log_n - n0, 1);
    n0 = log_n;
    tmr_in[7:5] = 3'b000;
    tick(20);
    check(log_n - n0 == 2, "R5 fall: falling and both channels", log_n - n0, 2);
    if (log_n - n0 == 2)
      check(log_ch[n0] == 5 && log_ch[n0+1] == 6, "R2 order on fall",
            {log_ch[n0][15:0], log_ch[n0+1][15:0]}, {16'd5, 16'd6});
    clear_all();
  endtask

  task automatic t_priority();
    int n0;
    cfg(8, 1'b1, 3'd1, 2'b00);
    cfg(4, 1'b1, 3'd1, 2'b00);
    cfg(2, 1'b1, 3'd1, 2'b00);
    cfg(0, 1'b1, 3'd2, 2'b00);
    n0 = log_n;
    strobe(7'b000_0110);
    tick(30);
    check(log_n - n0 == 4, "R10 four transfers", log_n - n0, 4);
    if (log_n - n0 == 4)
      check(log_ch[n0] == 0 && log_ch[n0+1] == 2 && log_ch[n0+2] == 4 && log_ch[n0+3] == 8,
            "R2 fixed priority order",
            {log_ch[n0][7:0], log_ch[n0+1][7:0], log_ch[n0+2][7:0], log_ch[n0+3][7:0]},
            32'h00020408);
    clear_all();
  endtask

  task automatic t_select();
    int n0;
    cfg(4, 1'b1, 3'd5, 2'b11);
    cfg(1, 1'b0, 3'd0, 2'b00);
    n0 = log_n;
    strobe(7'b000_1000);
    tmr_in[4] = 1'b1;
    tick(12);
    check(log_n == n0 && bus_req === 1'b0, "R4 other source ignored", log_n - n0, 0);
    strobe(7'b000_0001);
    tick(12);
    check(log_n == n0, "R3 disabled channel ignored", log_n - n0, 0);
    strobe(7'b010_0000);
    tick(12);
    check(log_n - n0 == 1 && log_ch[n0] == 4, "R4 selected line served", log_n - n0, 1);
    tmr_in[4] = 1'b0;
    clear_all();
  endtask

  task automatic t_hold();
    int n0;
    cfg(8, 1'b1, 3'd3, 2'b00);
    cfg(2, 1'b1, 3'd4, 2'b00);
    cfg(9, 1'b1, 3'd6, 2'b00);
    n0 = log_n;
    gnt_block = 1'b1;
    strobe(7'b000_1000);
    tick(2);
    check(bus_req === 1'b1 && xfer_ch === 4'd8, "R7 request held", {bus_req, xfer_ch}, {1'b1, 4'd8});
    strobe(7'b101_0000);
    tick(4);
    check(rd_en === 1'b0 && xfer_ch === 4'd8, "R11 no read, channel kept",
          {rd_en, xfer_ch}, {1'b0, 4'd8});
    chan_en[9] = 1'b0;
    tick(2);
    gnt_block = 1'b0;
    tick(20);
    check(log_n - n0 == 2, "R3 withdrawn channel dropped", log_n - n0, 2);
    if (log_n - n0 == 2)
      check(log_ch[n0] == 8 && log_ch[n0+1] == 2, "R11 parked then higher",
            {log_ch[n0][15:0], log_ch[n0+1][15:0]}, {16'd8, 16'd2});
    clear_all();
  endtask

  initial begin
    #(8 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    rst = 1'b0;
    tick(2);
    t_reset();
    t_latency();
    t_edges();
    t_priority();
    t_select();
    t_hold();
    check(data_bad == 0, "R8 every write carries read data", data_bad, 0);
    check(rel_bad == 0, "R9 bus released after every write", rel_bad, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule